// File: doc/BRIEF.md
# Serial Character Duration Timer

This block measures out the time that one asynchronous serial character occupies on the line, counted in input clock cycles. It holds a mode register and a bit-rate register. From the character-length, parity and stop-length fields of the mode register it works out how many bits one character has. From the bit-rate value and a two-bit clock prescale field it works out how long one bit lasts. The product of the two is loaded into a down-counter when a start strobe arrives.

While the count runs the block raises a busy flag. When the count expires it raises a done pulse for one clock. The timing engine of a serial port uses this pulse to pace back-to-back characters, so the counter spans a whole character rather than a single bit.

Both configuration registers are frozen while the transmit enable or the receive enable is set. A frame timing therefore cannot change while traffic is running.

Top module: `frame_span_timer`

## Requirements
- R1: After reset the bit-rate register reads 0xFF, the mode register reads 0x00, and busy and done are low.
- R2: The bit count of a character is the data bits plus the parity bits plus the stop bits. Data bits are 8 when mode bit 6 is 0 and 7 when it is 1. Mode bit 5 set adds one parity bit. Stop bits are 1 when mode bit 3 is 0 and 2 when it is 1.
- R3: One bit lasts 2^BASE_LOG2 × rate × 4^cks input clocks, where cks is mode bits [1:0] and the default BASE_LOG2 of 5 gives 32. The character span S is the bit count times the bit time.
- R4: For a start sampled at clock edge E with S ≥ 1, busy is high from E until the edge E+S, and done is high in the cycle that follows edge E+S.
- R5: Done is high for exactly one cycle. With no further start, done stays low afterwards.
- R6: A start that arrives while the counter is busy reloads the full span. No done appears for the abandoned count.
- R7: When the rate is 0, S is 0. Done is high in the cycle right after the start edge, and busy stays low.
- R8: A write to the mode or bit-rate register is ignored while tx_en or rx_en is high.
- R9: With both enables low, a write takes effect at the next clock edge. A start in the same cycle as a write uses the values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; locks the configuration |
| rx_en | input | 1 | Receive enable; locks the configuration |
| mode_we | input | 1 | Mode register write strobe |
| mode_wd | input | 8 | Mode register write data |
| rate_we | input | 1 | Bit-rate register write strobe |
| rate_wd | input | RATE_W | Bit-rate register write data |
| start | input | 1 | Load the character span and begin counting |
| mode_q | output | 8 | Current mode register |
| rate_q | output | RATE_W | Current bit-rate register |
| busy | output | 1 | Count in progress |
| done | output | 1 | One-cycle pulse when the count expires |

## Verification
The checker assumes that the enables and write strobes change only between clock edges. It also assumes that start is a level sampled at each edge, so that a start held high counts as repeated restarts. The stimulus drives every input on the falling edge and lowers start after one cycle, except where a restart is intended.

The bench instance uses a base multiplier of 2 rather than 32. With that setting it can sweep every combination of character length, parity, stop length and prescale against several small rates. The long spans are thereby replaced by short ones that follow the same arithmetic.

// File: rtl/fst_pkg.sv
package fst_pkg;
   localparam int MODE_W    = 8;
   localparam int CKS_W     = 2;
   localparam int CKS_LSB   = 0;
   localparam int STOP_BIT  = 3;
   localparam int PAR_BIT   = 5;
   localparam int LEN_BIT   = 6;
   localparam int DATA_LONG = 8;
   localparam int BITS_W    = 4;
   localparam int MAX_BITS  = DATA_LONG + 1 + 2;

   typedef struct packed {
      logic             len7;
      logic             par_en;
      logic             stop2;
      logic [CKS_W-1:0] cks;
   } mode_fields_t;

   function automatic mode_fields_t unpack_mode(input logic [MODE_W-1:0] m);
      mode_fields_t f;
      f.len7   = m[LEN_BIT];
      f.par_en = m[PAR_BIT];
      f.stop2  = m[STOP_BIT];
      f.cks    = m[CKS_LSB +: CKS_W];
      return f;
   endfunction

   function automatic logic [BITS_W-1:0] char_bits(input mode_fields_t f);
      return BITS_W'(DATA_LONG) - BITS_W'(f.len7) + BITS_W'(f.par_en)
             + BITS_W'(1) + BITS_W'(f.stop2);
   endfunction

   function automatic longint max_span(input int rate_w, input int base_log2);
      return longint'(MAX_BITS) * ((longint'(1) << rate_w) - 1)
             * (longint'(1) << (base_log2 + 2 * ((1 << CKS_W) - 1)));
   endfunction
endpackage

// File: rtl/fst_cfg_regs.sv
module fst_cfg_regs
   import fst_pkg::*;
#(
   parameter int                 RATE_W   = 8,
   parameter logic [RATE_W-1:0]  RATE_RST = '1,
   parameter logic [MODE_W-1:0]  MODE_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wd,
   input  logic              rate_we,
   input  logic [RATE_W-1:0] rate_wd,
   output logic [MODE_W-1:0] mode_q,
   output logic [RATE_W-1:0] rate_q
);
   logic mode_take;
   logic rate_take;

   assign mode_take = mode_we && !lock;
   assign rate_take = rate_we && !lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RST;
         rate_q <= RATE_RST;
      end else begin
         if (mode_take) mode_q <= mode_wd;
         if (rate_take) rate_q <= rate_wd;
      end
   end
endmodule

// File: rtl/fst_span_calc.sv
module fst_span_calc
   import fst_pkg::*;
#(
   parameter int RATE_W    = 8,
   parameter int BASE_LOG2 = 5,
   parameter int CNT_W     = 23,
   parameter int MUL_STYLE = 0
) (
   input  mode_fields_t      cfg,
   input  logic [RATE_W-1:0] rate,
   output logic [CNT_W-1:0]  span
);
   logic [BITS_W-1:0] nbits;
   logic [CNT_W-1:0]  bit_time;

   assign nbits    = char_bits(cfg);
   assign bit_time = CNT_W'(rate) << (BASE_LOG2 + 2 * int'(cfg.cks));

   if (MUL_STYLE == 0) begin : g_mul
      assign span = bit_time * CNT_W'(nbits);
   end else begin : g_shift_add
      logic [CNT_W-1:0] part [BITS_W];
      for (genvar i = 0; i < BITS_W; i++) begin : g_part
         assign part[i] = nbits[i] ? (bit_time << i) : '0;
      end
      always_comb begin
         span = '0;
         for (int j = 0; j < BITS_W; j++) span = span + part[j];
      end
   end
endmodule

// File: rtl/fst_down_cnt.sv
module fst_down_cnt #(
   parameter int CNT_W = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy,
   output logic             done
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (load) begin
         cnt  <= load_val;
         done <= (load_val == '0);
      end else if (cnt != '0) begin
         cnt  <= cnt - CNT_W'(1);
         done <= (cnt == CNT_W'(1));
      end else begin
         done <= 1'b0;
      end
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/frame_span_timer.sv
module frame_span_timer
   import fst_pkg::*;
#(
   parameter int RATE_W    = 8,
   parameter int BASE_LOG2 = 5,
   parameter int MUL_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              mode_we,
   input  logic [7:0]        mode_wd,
   input  logic              rate_we,
   input  logic [RATE_W-1:0] rate_wd,
   input  logic              start,
   output logic [7:0]        mode_q,
   output logic [RATE_W-1:0] rate_q,
   output logic              busy,
   output logic              done
);
   localparam longint SPAN_MAX = max_span(RATE_W, BASE_LOG2);
   localparam int     CNT_W    = $clog2(SPAN_MAX + 1);

   if (RATE_W < 1 || RATE_W > 16) begin : g_bad_rate
      $error("frame_span_timer: RATE_W out of range");
   end
   if (BASE_LOG2 < 0 || BASE_LOG2 > 8) begin : g_bad_base
      $error("frame_span_timer: BASE_LOG2 out of range");
   end
   if (MUL_STYLE < 0 || MUL_STYLE > 1) begin : g_bad_style
      $error("frame_span_timer: MUL_STYLE must be 0 or 1");
   end

   logic             cfg_lock;
   mode_fields_t     fields;
   logic [CNT_W-1:0] span;

   assign cfg_lock = tx_en | rx_en;
   assign fields   = unpack_mode(mode_q);

   fst_cfg_regs #(
      .RATE_W   (RATE_W),
      .RATE_RST ({RATE_W{1'b1}}),
      .MODE_RST ('0)
   ) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock    (cfg_lock),
      .mode_we (mode_we),
      .mode_wd (mode_wd),
      .rate_we (rate_we),
      .rate_wd (rate_wd),
      .mode_q  (mode_q),
      .rate_q  (rate_q)
   );

   fst_span_calc #(
      .RATE_W    (RATE_W),
      .BASE_LOG2 (BASE_LOG2),
      .CNT_W     (CNT_W),
      .MUL_STYLE (MUL_STYLE)
   ) calc_i (
      .cfg  (fields),
      .rate (rate_q),
      .span (span)
   );

   fst_down_cnt #(
      .CNT_W (CNT_W)
   ) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .load_val (span),
      .busy     (busy),
      .done     (done)
   );
endmodule

// File: rtl/fst_chk.sv
module fst_chk #(
   parameter int RATE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_en,
   input logic              rx_en,
   input logic              start,
   input logic [7:0]        mode_q,
   input logic [RATE_W-1:0] rate_q,
   input logic              busy,
   input logic              done
);
   AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en || rx_en) |=> $stable(mode_q)); // R8
   AST_RATE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en || rx_en) |=> $stable(rate_q)); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !done); // R5
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R4
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && rate_q != '0) |=> busy); // R6
   AST_ZERO_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && rate_q == '0) |=> (done && !busy)); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !busy); // R4
endmodule

bind frame_span_timer fst_chk #(.RATE_W(RATE_W)) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .tx_en  (tx_en),
   .rx_en  (rx_en),
   .start  (start),
   .mode_q (mode_q),
   .rate_q (rate_q),
   .busy   (busy),
   .done   (done)
);

// File: tb/frame_span_timer_tb_top.sv
module frame_span_timer_tb_top;
   localparam int BASE = 1;
   localparam int RW   = 8;
   localparam int LIMIT = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0, rx_en = 1'b0;
   logic mode_we = 1'b0, rate_we = 1'b0, start = 1'b0;
   logic [7:0] mode_wd = '0;
   logic [RW-1:0] rate_wd = '0;
   logic [7:0] mode_q;
   logic [RW-1:0] rate_q;
   logic busy, done;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   frame_span_timer #(.RATE_W(RW), .BASE_LOG2(BASE), .MUL_STYLE(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
      .mode_we(mode_we), .mode_wd(mode_wd), .rate_we(rate_we), .rate_wd(rate_wd),
      .start(start), .mode_q(mode_q), .rate_q(rate_q), .busy(busy), .done(done));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint exp_span(input logic [7:0] m, input logic [RW-1:0] r);
      longint nb;
      nb = (m[6] ? 7 : 8) + (m[5] ? 1 : 0) + (m[3] ? 2 : 1);
      return nb * longint'(r) * (longint'(1) << (BASE + 2 * int'(m[1:0])));
   endfunction

   task automatic wr(input logic [7:0] m, input logic [RW-1:0] r);
      @(negedge clk);
      mode_we = 1'b1; mode_wd = m; rate_we = 1'b1; rate_wd = r;
      @(negedge clk);
      mode_we = 1'b0; rate_we = 1'b0;
   endtask

   // start (optionally with a same-cycle write), then time the span
   task automatic measure(input longint s, input string req,
                          input bit with_wr, input logic [RW-1:0] new_rate);
      int k;
      int busy_bad;
      @(negedge clk);
      start = 1'b1;
      if (with_wr) begin rate_we = 1'b1; rate_wd = new_rate; end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0; rate_we = 1'b0;
      k = 0; busy_bad = 0;
      while (!done && k < LIMIT) begin
         if (!busy) busy_bad++;
         @(posedge clk);
         @(negedge clk);
         k++;
      end
      chk(longint'(k) == s, {req, " span"}, k, s);
      chk(busy_bad == 0 && !busy, {req, " busy window R4"}, busy_bad, 0);
      @(negedge clk);
      chk(!done, {req, " single done R5"}, done, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] m;
      logic [7:0] old_m;
      logic [RW-1:0] old_r;
      int extra_done;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rate_q == 8'hFF, "R1 rate reset", rate_q, 8'hFF);
      chk(mode_q == 8'h00, "R1 mode reset", mode_q, 0);
      chk(!busy && !done, "R1 busy/done reset", {busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 sweep over all field combinations; R7 covered by rate 0
      for (int c = 0; c < 32; c++) begin
         m = '0;
         m[1:0] = c[1:0];
         m[3] = c[2];
         m[5] = c[3];
         m[6] = c[4];
         for (int ri = 0; ri < 3; ri++) begin
            logic [RW-1:0] r;
            r = (ri == 0) ? 8'd0 : (ri == 1) ? 8'd1 : 8'd3;
            if (c[4] && ri == 2 && c[1:0] == 2'd3) r = 8'd2;
            wr(m, r);
            measure(exp_span(m, r), (r == 0) ? "R7 zero rate" : "R2 R3 sweep", 1'b0, '0);
         end
      end
      wr(8'h00, 8'hFF);
      measure(exp_span(8'h00, 8'hFF), "R3 full rate", 1'b0, '0);

      // R6 restart while busy
      wr(8'h00, 8'd5);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      extra_done = 0;
      repeat (10) begin
         @(negedge clk);
         if (done) extra_done++;
      end
      chk(busy, "R6 busy before restart", busy, 1);
      measure(exp_span(8'h00, 8'd5), "R6 restart", 1'b0, '0);
      chk(extra_done == 0, "R6 no early done", extra_done, 0);

      // R8 lock by each enable
      old_m = mode_q; old_r = rate_q;
      tx_en = 1'b1;
      wr(8'h5A, 8'h11);
      chk(mode_q == old_m && rate_q == old_r, "R8 tx lock", {mode_q, rate_q}, {old_m, old_r});
      tx_en = 1'b0; rx_en = 1'b1;
      wr(8'h6B, 8'h22);
      chk(mode_q == old_m && rate_q == old_r, "R8 rx lock", {mode_q, rate_q}, {old_m, old_r});
      measure(exp_span(old_m, old_r), "R8 locked span", 1'b0, '0);
      rx_en = 1'b0;

      // R9 write applies; same-cycle start uses prior values
      wr(8'h48, 8'd1);
      chk(mode_q == 8'h48 && rate_q == 8'd1, "R9 write applied", {mode_q, rate_q}, {8'h48, 8'd1});
      measure(exp_span(8'h48, 8'd1), "R9 same-cycle start", 1'b1, 8'd2);
      chk(rate_q == 8'd2, "R9 same-cycle write", rate_q, 2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule